// File: doc/BRIEF.md
# I/O Access Width Fallback Splitter

This block sits between a processor-side port for I/O requests and a sized I/O target bus. A request gives an address, a width of 8, 16 or 32 bits, a direction and write data. When the address is aligned, the request goes out first at its full width. If no target acknowledges that width, the block tries again with pieces half as wide. Each of those pieces can fall back in the same way, down to single bytes. When the address is not aligned, the request is split at once into pieces that are naturally aligned. Read data from all the pieces is put back into the right byte lanes. The requester gets one completion pulse after the last piece.

Only one piece is on the target bus at a time, and each piece takes one cycle. The target answers in the same cycle through an acknowledge input and a read data input. If a byte piece gets no acknowledge, nothing is left to retry. The block marks the transaction as failed, returns all-ones for that byte and carries on with the remaining bytes. A configuration input limits the processor bus to 16 bits. In that mode a 32-bit request never tries a 32-bit transfer. A second input turns on a one-cycle log pulse for every byte that goes unanswered.

Top module: `io_width_splitter`

## Requirements
- R1: After reset, req_ready is 1 and rsp_done and tgt_valid are 0. A request is accepted at a rising edge where req_valid and req_ready are both 1. From the next cycle the pieces go out one per cycle. req_ready stays 0 until the transaction retires. rsp_done is a one-cycle pulse in the cycle after the last piece.
- R2: A 16-bit request (req_size 01) at an even address is first issued as one 16-bit piece. If that piece gets no acknowledge, the next two cycles carry byte pieces to the address and to the address plus one.
- R3: A 16-bit request at an odd address is never issued as a 16-bit piece. It goes out as two byte pieces, in rising address order.
- R4: A 32-bit request (req_size 10) whose address is a multiple of four is first issued as one 32-bit piece. If that piece gets no acknowledge, it is followed by a 16-bit piece at the address and then one at the address plus two.
- R5: A 32-bit request whose address modulo four is 2 is issued as two 16-bit pieces. When the address modulo four is 1 or 3, it is issued as a byte, then a 16-bit piece at the address plus one, then a byte at the address plus three.
- R6: A 16-bit piece produced by a split or a fallback follows R2 itself. A 32-bit request to a target that takes only bytes therefore issues 32, 16, 8, 8, 16, 8, 8.
- R7: When a byte piece gets no acknowledge, the transaction still completes. rsp_err is 1 at rsp_done, and that byte of rsp_rdata reads FF. nack_log is 1 during that piece's cycle only when log_en is 1.
- R8: The piece at byte offset k from the request address carries req_wdata bits from 8k upward. The piece's data is right-aligned on tgt_wdata, and the lanes above its width are zero. Read data of the piece, right-aligned on tgt_rdata, is placed at the same offsets in rsp_rdata. Lanes above the request width read 0.
- R9: When cfg_bus16 is 1 at acceptance, no 32-bit piece is issued. An aligned 32-bit request starts as two 16-bit pieces.
- R10: tgt_size codes are 00 for a byte, 01 for 16 bits and 10 for 32 bits. A byte request issues exactly one byte piece. A request with req_size 11 is handled as a 32-bit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus16 | input | 1 | Limit the processor bus to 16 bits; sampled when a request is accepted |
| log_en | input | 1 | Enable the no-response log pulse |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Request I/O address |
| req_size | input | 2 | Request width: 00 byte, 01 16-bit, 10 or 11 32-bit |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, with the lowest address in the least significant byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Reassembled read data, valid with rsp_done |
| rsp_err | output | 1 | At least one byte went unanswered, valid with rsp_done |
| tgt_valid | output | 1 | Piece on the target bus this cycle |
| tgt_addr | output | AW | Piece address |
| tgt_size | output | 2 | Piece width code |
| tgt_write | output | 1 | Piece direction |
| tgt_wdata | output | 32 | Piece write data, right-aligned |
| tgt_ack | input | 1 | Target accepts the piece at this width, in the same cycle |
| tgt_rdata | input | 32 | Piece read data, right-aligned, in the same cycle |
| nack_log | output | 1 | Pulse for an unanswered byte piece while log_en is 1 |

## Verification
The internal width cap and the byte offset decide every piece, so corrupting either one shows up on the target bus at once. The next piece has the wrong address or the wrong size, or a fallback step is skipped, in the very cycle after the faulty update. A wrong merge of read lanes or a lost error flag stays hidden until rsp_done, at most seven cycles later. There it appears as wrong bytes or a wrong rsp_err. A wrong completion count shows as a rsp_done pulse that comes before or after the cycle following the last expected piece.

// File: rtl/iows_pkg.sv
package iows_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(LANES) + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } state_e;

    function automatic logic [OFS_W-1:0] size_bytes(size_e s);
        logic [OFS_W-1:0] n;
        unique case (s)
            SZ_BYTE: n = OFS_W'(1);
            SZ_HALF: n = OFS_W'(2);
            default: n = OFS_W'(4);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/iows_piece_plan.sv
// Picks the widest naturally aligned piece that fits the remaining bytes
// and does not exceed the current width cap.
module iows_piece_plan
    import iows_pkg::*;
(
    input  logic [1:0]       addr_lo,
    input  logic [OFS_W-1:0] remain,
    input  size_e            cap,
    output size_e            piece
);

    logic fits_word;
    logic fits_half;

    always_comb begin
        fits_word = (cap == SZ_WORD) && (remain >= OFS_W'(4)) && (addr_lo == 2'b00);
        fits_half = (cap != SZ_BYTE) && (remain >= OFS_W'(2)) && !addr_lo[0];
        if (fits_word) begin
            piece = SZ_WORD;
        end else if (fits_half) begin
            piece = SZ_HALF;
        end else begin
            piece = SZ_BYTE;
        end
    end

endmodule

// File: rtl/iows_cap_track.sv
// Holds the width cap. A failed piece lowers the cap by one step until the
// byte offset has passed the end of that piece; then the home cap returns.
module iows_cap_track
    import iows_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  size_e            start_cap,
    input  size_e            home_cap,
    input  logic             step,
    input  logic             split,
    input  size_e            piece,
    input  logic [OFS_W-1:0] cur_ofs,
    input  logic [OFS_W-1:0] next_ofs,
    output size_e            cap
);

    size_e            cap_q;
    logic [OFS_W-1:0] end_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= SZ_WORD;
            end_q <= '0;
        end else if (start) begin
            cap_q <= start_cap;
            end_q <= '0;
        end else if (step) begin
            if (split) begin
                cap_q <= size_e'(2'(piece) - 2'd1);
                end_q <= cur_ofs + size_bytes(piece);
            end else if (next_ofs >= end_q) begin
                cap_q <= home_cap;
            end
        end
    end

    assign cap = cap_q;

endmodule

// File: rtl/iows_lanes.sv
// Byte lane steering: moves write data down to the piece and read data up
// into the reassembly register.
module iows_lanes
    import iows_pkg::*;
(
    input  logic [1:0]        ofs,
    input  size_e             piece,
    input  logic              ack,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] rdata_in,
    input  logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] piece_wdata,
    output logic [DATA_W-1:0] rdata_next
);

    logic [OFS_W-1:0] nb;
    assign nb = size_bytes(piece);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [1:0]       k;
        logic             in_piece;
        logic [OFS_W-1:0] src;

        always_comb begin
            k        = 2'(i) - ofs;
            in_piece = (OFS_W'(i) >= {1'b0, ofs}) && ({1'b0, k} < nb);
            if (in_piece && ack) begin
                rdata_next[8*i +: 8] = rdata_in[{k, 3'b000} +: 8];
            end else if (in_piece && (piece == SZ_BYTE)) begin
                rdata_next[8*i +: 8] = 8'hFF;
            end else begin
                rdata_next[8*i +: 8] = rdata_q[8*i +: 8];
            end
        end

        always_comb begin
            src = OFS_W'(i) + {1'b0, ofs};
            if ((OFS_W'(i) < nb) && (src < OFS_W'(LANES))) begin
                piece_wdata[8*i +: 8] = wdata_q[{src[1:0], 3'b000} +: 8];
            end else begin
                piece_wdata[8*i +: 8] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/io_width_splitter.sv
module io_width_splitter
    import iows_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus16,
    input  logic              log_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              tgt_valid,
    output logic [AW-1:0]     tgt_addr,
    output logic [1:0]        tgt_size,
    output logic              tgt_write,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_ack,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              nack_log
);

    state_e state_q, state_d;

    logic [AW-1:0]     base_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              bus16_q;
    logic [OFS_W-1:0]  total_q;
    logic [OFS_W-1:0]  ofs_q;

    size_e             req_sz;
    size_e             cap;
    size_e             piece;
    logic [AW-1:0]     cur_addr;
    logic [OFS_W-1:0]  remain;
    logic [OFS_W-1:0]  ofs_next;
    logic [DATA_W-1:0] rdata_next;
    logic [DATA_W-1:0] piece_wdata;
    logic              accept;
    logic              issuing;
    logic              nacked;
    logic              split;
    logic              last;

    always_comb begin
        unique case (req_size)
            2'b00:   req_sz = SZ_BYTE;
            2'b01:   req_sz = SZ_HALF;
            default: req_sz = SZ_WORD;
        endcase
    end

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign issuing  = (state_q == ST_ISSUE);
    assign cur_addr = base_q + AW'(ofs_q);
    assign remain   = total_q - ofs_q;
    assign nacked   = issuing && !tgt_ack;
    assign split    = nacked && (piece != SZ_BYTE);

    always_comb begin
        if (tgt_ack) begin
            ofs_next = ofs_q + size_bytes(piece);
        end else if (piece == SZ_BYTE) begin
            ofs_next = ofs_q + OFS_W'(1);
        end else begin
            ofs_next = ofs_q;
        end
        last = (ofs_next == total_q);
    end

    iows_piece_plan u_plan (
        .addr_lo (cur_addr[1:0]),
        .remain  (remain),
        .cap     (cap),
        .piece   (piece)
    );

    iows_cap_track u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_cap (cfg_bus16 ? SZ_HALF : SZ_WORD),
        .home_cap  (bus16_q ? SZ_HALF : SZ_WORD),
        .step      (issuing),
        .split     (split),
        .piece     (piece),
        .cur_ofs   (ofs_q),
        .next_ofs  (ofs_next),
        .cap       (cap)
    );

    iows_lanes u_lanes (
        .ofs         (ofs_q[1:0]),
        .piece       (piece),
        .ack         (tgt_ack),
        .wdata_q     (wdata_q),
        .rdata_in    (tgt_rdata),
        .rdata_q     (rdata_q),
        .piece_wdata (piece_wdata),
        .rdata_next  (rdata_next)
    );

    // Transitions: T_ACCEPT (IDLE->ISSUE), T_NEXT_PIECE (ISSUE->ISSUE),
    // T_FINAL (ISSUE->RESP), T_RETIRE (RESP->IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (last)      state_d = ST_RESP;
            ST_RESP:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            bus16_q <= 1'b0;
            total_q <= '0;
            ofs_q   <= '0;
        end else if (accept) begin
            base_q  <= req_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            err_q   <= 1'b0;
            bus16_q <= cfg_bus16;
            total_q <= size_bytes(req_sz);
            ofs_q   <= '0;
        end else if (issuing) begin
            ofs_q   <= ofs_next;
            rdata_q <= rdata_next;
            if (nacked && (piece == SZ_BYTE)) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
        rsp_err   = err_q;
        tgt_valid = issuing;
        tgt_addr  = cur_addr;
        tgt_size  = 2'(piece);
        tgt_write = write_q;
        tgt_wdata = piece_wdata;
        nack_log  = nacked && (piece == SZ_BYTE) && log_en;
    end

endmodule

// File: rtl/iows_checker.sv
module iows_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_bus16,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          tgt_valid,
    input logic [AW-1:0] tgt_addr,
    input logic [1:0]    tgt_size,
    input logic          tgt_write,
    input logic [31:0]   tgt_wdata,
    input logic          tgt_ack
);

    AST_PIECE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> ((tgt_size != 2'd1) || !tgt_addr[0]) && ((tgt_size != 2'd2) || (tgt_addr[1:0] == 2'b00))); // R5

    AST_FALLBACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !tgt_ack && (tgt_size != 2'd0)) |=>
            (tgt_valid && (tgt_addr == $past(tgt_addr)) && (tgt_size == $past(tgt_size) - 2'd1))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!tgt_valid && !rsp_done)); // R1

    AST_NO_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && cfg_bus16) |-> (tgt_size != 2'd2)); // R9

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && tgt_write && (tgt_size == 2'd0)) |-> (tgt_wdata[31:8] == 24'h0)); // R8

endmodule

bind io_width_splitter iows_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_bus16 (cfg_bus16),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .tgt_valid (tgt_valid),
    .tgt_addr  (tgt_addr),
    .tgt_size  (tgt_size),
    .tgt_write (tgt_write),
    .tgt_wdata (tgt_wdata),
    .tgt_ack   (tgt_ack)
);

// File: tb/tb_io_width_splitter.sv
`timescale 1ns/1ps
module tb_io_width_splitter;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_bus16 = 1'b0;
    logic          log_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_done;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic          tgt_valid;
    logic [AW-1:0] tgt_addr;
    logic [1:0]    tgt_size;
    logic          tgt_write;
    logic [31:0]   tgt_wdata;
    logic          tgt_ack;
    logic [31:0]   tgt_rdata;
    logic          nack_log;

    always #2.5 clk = ~clk;

    io_width_splitter #(.AW(AW)) dut (.*);

    // Target model: region = addr[7:4]
    // 0 bytes only, 1 bytes and 16-bit, 2 all widths, 3 nothing, 4 16-bit only
    function automatic logic mdl_ack(logic [AW-1:0] a, logic [1:0] s);
        case (a[7:4])
            4'h0:    return s == 2'd0;
            4'h1:    return s <= 2'd1;
            4'h2:    return 1'b1;
            4'h3:    return 1'b0;
            4'h4:    return s == 2'd1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    assign tgt_ack = tgt_valid && mdl_ack(tgt_addr, tgt_size);
    always_comb begin
        tgt_rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nbytes(tgt_size)) tgt_rdata[8*k +: 8] = mem_byte(tgt_addr + AW'(k));
        end
    end

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic          write;
        logic [31:0]   wdata;
        logic          log;
        string         tag;
    } att_t;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic        write;
        string       tag;
    } done_t;

    att_t  exp_att[$];
    done_t exp_done[$];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [AW-1:0] cur_base;
    logic [31:0]   cur_wdata;
    logic          cur_write;
    logic          cur_log;
    logic [31:0]   rd_acc;
    logic          err_acc;
    string         cur_tag;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push_att(int o, logic [1:0] s, output logic ok);
        att_t t;
        logic [31:0] sh;
        t.addr  = cur_base + AW'(o);
        t.size  = s;
        t.write = cur_write;
        sh      = cur_wdata >> (8 * o);
        t.wdata = (s == 2'd0) ? {24'h0, sh[7:0]} : (s == 2'd1) ? {16'h0, sh[15:0]} : sh;
        ok      = mdl_ack(t.addr, s);
        t.log   = !ok && (s == 2'd0) && cur_log;
        t.tag   = cur_tag;
        exp_att.push_back(t);
        if (ok) begin
            for (int k = 0; k < nbytes(s); k++) rd_acc[8*(o+k) +: 8] = mem_byte(t.addr + AW'(k));
        end
    endtask

    task automatic ref_byte(int o);
        logic ok;
        push_att(o, 2'd0, ok);
        if (!ok) begin
            rd_acc[8*o +: 8] = 8'hFF;
            err_acc = 1'b1;
        end
    endtask

    task automatic ref_half(int o);
        logic ok;
        push_att(o, 2'd1, ok);
        if (!ok) begin
            ref_byte(o);
            ref_byte(o + 1);
        end
    endtask

    task automatic ref_word(int o);
        logic ok;
        push_att(o, 2'd2, ok);
        if (!ok) begin
            ref_half(o);
            ref_half(o + 2);
        end
    endtask

    task automatic do_req(string tag, logic [AW-1:0] a, logic [1:0] s, logic w,
                          logic [31:0] wd, logic b16, logic le);
        done_t d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_base = a; cur_wdata = wd; cur_write = w; cur_log = le; cur_tag = tag;
        rd_acc = '0; err_acc = 1'b0;
        if (s == 2'd0) begin
            ref_byte(0);
        end else if (s == 2'd1) begin
            if (a[0]) begin ref_byte(0); ref_byte(1); end
            else ref_half(0);
        end else begin
            case (a[1:0])
                2'd0: if (b16) begin ref_half(0); ref_half(2); end else ref_word(0);
                2'd2: begin ref_half(0); ref_half(2); end
                default: begin ref_byte(0); ref_half(1); ref_byte(3); end
            endcase
        end
        d.rdata = rd_acc; d.err = err_acc; d.write = w; d.tag = tag;
        exp_done.push_back(d);
        cfg_bus16 = b16; log_en = le;
        req_addr = a; req_size = s; req_write = w; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_done.size() != 0) @(negedge clk);
    endtask

    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_valid) begin
                if (exp_att.size() == 0) begin
                    chk(1'b0, "R1", "unexpected piece addr", 32'(tgt_addr), 32'h0);
                end else begin
                    att_t t;
                    t = exp_att.pop_front();
                    chk(tgt_addr == t.addr, t.tag, "piece addr", 32'(tgt_addr), 32'(t.addr));
                    chk(tgt_size == t.size, t.tag, "piece size", 32'(tgt_size), 32'(t.size));
                    chk(tgt_write == t.write, t.tag, "piece dir", 32'(tgt_write), 32'(t.write));
                    if (t.write) chk(tgt_wdata == t.wdata, t.tag, "piece wdata", tgt_wdata, t.wdata);
                    chk(nack_log == t.log, t.tag, "nack_log", 32'(nack_log), 32'(t.log));
                    chk(!req_ready, "R1", "ready while busy", 32'(req_ready), 32'h0);
                end
            end
            if (rsp_done) begin
                if (exp_done.size() == 0) begin
                    chk(1'b0, "R1", "unexpected done", 32'h1, 32'h0);
                end else begin
                    done_t d;
                    d = exp_done.pop_front();
                    chk(exp_att.size() == 0 && prev_valid, "R1", "done timing",
                        32'(exp_att.size()), 32'h0);
                    chk(rsp_err == d.err, d.tag, "rsp_err", 32'(rsp_err), 32'(d.err));
                    if (!d.write) chk(rsp_rdata == d.rdata, d.tag, "rsp_rdata", rsp_rdata, d.rdata);
                end
            end
            prev_valid <= tgt_valid;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
        chk(rsp_done == 1'b0, "R1", "reset done", 32'(rsp_done), 32'h0);
        chk(tgt_valid == 1'b0, "R1", "reset tgt_valid", 32'(tgt_valid), 32'h0);

        do_req("R10", 16'h0003, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R10", 16'h0024, 2'd3, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R7",  16'h0035, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R7",  16'h0036, 2'd0, 1'b1, 32'h5A, 1'b0, 1'b0);
        do_req("R7",  16'h0030, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R2",  16'h0012, 2'd1, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R2",  16'h0002, 2'd1, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R2",  16'h0042, 2'd1, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R3",  16'h0013, 2'd1, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R3",  16'h0043, 2'd1, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R4",  16'h0020, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R4",  16'h0010, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R6",  16'h0000, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R6",  16'h0044, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R5",  16'h0026, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R5",  16'h0025, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R5",  16'h0027, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R5",  16'h0005, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R5",  16'h001E, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        do_req("R9",  16'h0020, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1);
        do_req("R9",  16'h0000, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1);
        do_req("R9",  16'h0023, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1);
        do_req("R8",  16'h0020, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b1);
        do_req("R8",  16'h0021, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b0, 1'b1);
        do_req("R8",  16'h0002, 2'd1, 1'b1, 32'h0000BEEF, 1'b0, 1'b1);
        do_req("R8",  16'h0044, 2'd2, 1'b1, 32'hCAFEF00D, 1'b0, 1'b1);
        do_req("R8",  16'h0028, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule